// File: doc/BRIEF.md
# Offset and Gain Calibration Engine

This block sits after the decimation filter of a 24-bit delta-sigma converter. It trims every conversion result with two stored words: an offset that is subtracted and an unsigned fixed-point gain that scales the difference. A command decoder starts a calibration with a one-cycle start pulse and a mode code. The engine then sequences sample capture over whole output-data periods, computes the new correction word or words, and switches back to correcting the live stream.

There are five calibration modes. Offset and gain can be calibrated separately or together, and each can run as self or system calibration. A self calibration drives a control output that isolates the converter inputs from the pins. A system calibration leaves the inputs connected and measures whatever is applied externally: zero for offset, positive full scale for gain. While any calibration runs, the engine raises an output that parks the offset DAC. It also holds the data-ready flag inactive and accepts no new request.

Top module: `calib_engine`

## Requirements
- R1: After reset the offset word is 0, the gain word is 0x400000 (1.0 with 22 fraction bits), busy, in_disconnect and odac_disable are 0, and drdy_n is 1.
- R2: cal_op codes are 0 = self offset+gain, 1 = self offset, 2 = self gain, 3 = system offset, 4 = system gain. A start pulse carrying any other code has no effect.
- R3: Each calibration phase spans two raw samples. The first sample lets the filter settle and is dropped. The second is the measurement.
- R4: An offset phase loads the offset word with the measured sample and leaves the gain word unchanged.
- R5: A gain phase computes d = sample − offset. It loads gain = min(floor(0x7FFFFF·2^22 / d), 0xFFFFFF), or 0xFFFFFF when d ≤ 0, and leaves the offset word unchanged.
- R6: Mode 0 runs an offset phase followed by a gain phase. The gain phase uses the offset word just measured, so the calibration spans four raw samples.
- R7: in_disconnect is 1 only while a self mode (0, 1, 2) is busy, and is never 1 during a system mode.
- R8: odac_disable is 1 exactly while busy is 1.
- R9: drdy_n goes to 1 when a calibration is accepted and returns to 0 on the cycle the calibration completes.
- R10: After a calibration completes, the next raw sample is discarded and produces no out_valid. The sample after that is published.
- R11: Outside calibration, every raw sample yields out_valid one cycle later with out_data = floor((raw − offset)·gain / 2^22), saturated to 0x7FFFFF or 0x800000. Each published sample drives drdy_n to 0.
- R12: No out_valid is produced while busy.
- R13: A start pulse that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | One-cycle calibration request |
| cal_op | input | 3 | Calibration mode code |
| raw_valid | input | 1 | Raw filter sample strobe |
| raw_data | input | 24 | Raw signed filter sample |
| out_valid | output | 1 | Corrected sample strobe |
| out_data | output | 24 | Corrected signed sample |
| drdy_n | output | 1 | Active-low data-ready flag |
| busy | output | 1 | Calibration in progress |
| in_disconnect | output | 1 | Isolate the converter inputs (self modes) |
| odac_disable | output | 1 | Park the offset DAC during calibration |
| offset_word | output | 24 | Current offset correction word |
| gain_word | output | 24 | Current gain correction word |

## Verification
The hardest case to reach is the combined mode: its gain measurement has to be divided against an offset captured only one phase earlier in the same run. A mismatch there shows only in the gain word and in later corrected samples. The stimulus therefore runs mode 0 with a negative offset sample, so the divisor differs from the raw full-scale sample. It then pushes corrected samples far enough to saturate in both directions. Request collisions are covered by a start pulse issued in the middle of a system gain run. The degenerate divisor is covered by a self gain run whose measurement lies below the stored offset.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [2:0] {
    OP_SELF_BOTH = 3'd0,
    OP_SELF_OFS  = 3'd1,
    OP_SELF_GAIN = 3'd2,
    OP_SYS_OFS   = 3'd3,
    OP_SYS_GAIN  = 3'd4
  } cal_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFS_SETTLE,
    ST_OFS_CAP,
    ST_GAIN_SETTLE,
    ST_GAIN_CAP,
    ST_DIVIDE
  } cal_state_e;

  function automatic logic op_is_legal(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic op_is_self(input logic [2:0] op);
    return op <= 3'd2;
  endfunction

  function automatic logic op_starts_offset(input logic [2:0] op);
    return (op == OP_SELF_BOTH) || (op == OP_SELF_OFS) || (op == OP_SYS_OFS);
  endfunction

endpackage

// File: rtl/calib_divider.sv
module calib_divider #(
  parameter int NUM_W = 45,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] den_q;

  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;
  logic             fits;

  always_comb begin
    shifted = {rem_q, q_q[NUM_W-1]};
    trial   = {1'b0, shifted} - {2'b00, den_q};
    fits    = !trial[DEN_W+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      rem_q <= '0;
      q_q   <= '0;
      den_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        cnt_q <= CNT_W'(NUM_W);
        rem_q <= '0;
        q_q   <= num;
        den_q <= den;
      end else if (run_q) begin
        rem_q <= fits ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q;

endmodule

// File: rtl/calib_correct.sv
module calib_correct #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              publish,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] gain,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int PW = 2 * DATA_W + 2;
  localparam logic signed [PW-1:0] SAT_HI = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SAT_LO = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  // (raw - offset) * gain, scaled down by the fraction bits with floor rounding, then clamped
  function automatic logic [DATA_W-1:0] apply_cal(input logic [DATA_W-1:0] r,
                                                   input logic [DATA_W-1:0] o,
                                                   input logic [DATA_W-1:0] g);
    logic signed [DATA_W:0] d;
    logic signed [PW-1:0]   p;
    logic signed [PW-1:0]   s;
    d = $signed({r[DATA_W-1], r}) - $signed({o[DATA_W-1], o});
    p = PW'(d) * PW'($signed({1'b0, g}));
    s = p >>> FRAC_W;
    if (s > SAT_HI)      return SAT_HI[DATA_W-1:0];
    else if (s < SAT_LO) return SAT_LO[DATA_W-1:0];
    else                 return s[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= publish;
      if (publish) out_data <= apply_cal(raw, offset, gain);
    end
  end

endmodule

// File: rtl/calib_seq.sv
module calib_seq
  import calib_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 22,
  parameter int NUM_W  = DATA_W - 1 + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic [2:0]        cal_op,
  input  logic              raw_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic              div_done,
  input  logic [NUM_W-1:0]  div_quo,
  output logic              div_start,
  output logic [DATA_W-1:0] div_den,
  output logic [DATA_W-1:0] offset_q,
  output logic [DATA_W-1:0] gain_q,
  output logic              busy,
  output logic              in_disconnect,
  output logic              odac_disable,
  output logic              drdy_n,
  output logic              publish,
  output logic              cal_accept,
  output logic              ofs_load,
  output logic              gain_load
);

  localparam logic [DATA_W-1:0] GAIN_ONE = DATA_W'(1) << FRAC_W;
  localparam logic [DATA_W-1:0] GAIN_MAX = '1;

  function automatic logic [DATA_W-1:0] clamp_gain(input logic [NUM_W-1:0] q);
    if (|q[NUM_W-1:DATA_W]) return GAIN_MAX;
    else                    return q[DATA_W-1:0];
  endfunction

  cal_state_e             state_q, state_d;
  logic [2:0]             mode_q;
  logic                   self_q;
  logic                   skip_q;
  logic                   finish;
  logic [DATA_W-1:0]      gain_next;
  logic signed [DATA_W:0] diff;
  logic                   diff_nonpos;

  assign busy          = (state_q != ST_IDLE);
  assign in_disconnect = busy && self_q;
  assign odac_disable  = busy;
  assign cal_accept    = cal_start && !busy && op_is_legal(cal_op);
  assign publish       = raw_valid && !busy && !skip_q;

  always_comb begin
    diff        = $signed({raw_data[DATA_W-1], raw_data}) - $signed({offset_q[DATA_W-1], offset_q});
    diff_nonpos = diff[DATA_W] || (diff == '0);
    div_den     = diff[DATA_W-1:0];
  end

  always_comb begin
    state_d   = state_q;
    ofs_load  = 1'b0;
    gain_load = 1'b0;
    gain_next = gain_q;
    div_start = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (cal_accept) state_d = op_starts_offset(cal_op) ? ST_OFS_SETTLE : ST_GAIN_SETTLE;
      ST_OFS_SETTLE:
        if (raw_valid) state_d = ST_OFS_CAP;
      ST_OFS_CAP:
        if (raw_valid) begin
          ofs_load = 1'b1;
          if (mode_q == OP_SELF_BOTH) state_d = ST_GAIN_SETTLE;
          else begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end
      ST_GAIN_SETTLE:
        if (raw_valid) state_d = ST_GAIN_CAP;
      ST_GAIN_CAP:
        if (raw_valid) begin
          if (diff_nonpos) begin
            gain_load = 1'b1;
            gain_next = GAIN_MAX;
            state_d   = ST_IDLE;
            finish    = 1'b1;
          end else begin
            div_start = 1'b1;
            state_d   = ST_DIVIDE;
          end
        end
      ST_DIVIDE:
        if (div_done) begin
          gain_load = 1'b1;
          gain_next = clamp_gain(div_quo);
          state_d   = ST_IDLE;
          finish    = 1'b1;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= 3'd0;
      self_q   <= 1'b0;
      skip_q   <= 1'b0;
      drdy_n   <= 1'b1;
      offset_q <= '0;
      gain_q   <= GAIN_ONE;
    end else begin
      state_q <= state_d;
      if (cal_accept) begin
        mode_q <= cal_op;
        self_q <= op_is_self(cal_op);
      end
      if (ofs_load)  offset_q <= raw_data;
      if (gain_load) gain_q   <= gain_next;
      if (finish)                          skip_q <= 1'b1;
      else if (raw_valid && !busy && skip_q) skip_q <= 1'b0;
      if (cal_accept)          drdy_n <= 1'b1;
      else if (finish || publish) drdy_n <= 1'b0;
    end
  end

endmodule

// File: rtl/calib_engine.sv
module calib_engine #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic [2:0]        cal_op,
  input  logic              raw_valid,
  input  logic [DATA_W-1:0] raw_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              drdy_n,
  output logic              busy,
  output logic              in_disconnect,
  output logic              odac_disable,
  output logic [DATA_W-1:0] offset_word,
  output logic [DATA_W-1:0] gain_word
);

  localparam int NUM_W = DATA_W - 1 + FRAC_W;
  localparam logic [NUM_W-1:0] FS_NUM = {{(DATA_W-1){1'b1}}, {FRAC_W{1'b0}}};

  logic              div_start;
  logic              div_done;
  logic [DATA_W-1:0] div_den;
  logic [NUM_W-1:0]  div_quo;
  logic              publish;
  logic              cal_accept;
  logic              ofs_load;
  logic              gain_load;

  calib_seq #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W),
    .NUM_W (NUM_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_start    (cal_start),
    .cal_op       (cal_op),
    .raw_valid    (raw_valid),
    .raw_data     (raw_data),
    .div_done     (div_done),
    .div_quo      (div_quo),
    .div_start    (div_start),
    .div_den      (div_den),
    .offset_q     (offset_word),
    .gain_q       (gain_word),
    .busy         (busy),
    .in_disconnect(in_disconnect),
    .odac_disable (odac_disable),
    .drdy_n       (drdy_n),
    .publish      (publish),
    .cal_accept   (cal_accept),
    .ofs_load     (ofs_load),
    .gain_load    (gain_load)
  );

  calib_divider #(
    .NUM_W(NUM_W),
    .DEN_W(DATA_W)
  ) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(div_start),
    .num  (FS_NUM),
    .den  (div_den),
    .done (div_done),
    .quo  (div_quo)
  );

  calib_correct #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W)
  ) u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .publish  (publish),
    .raw      (raw_data),
    .offset   (offset_word),
    .gain     (gain_word),
    .out_valid(out_valid),
    .out_data (out_data)
  );

endmodule

// File: rtl/calib_engine_chk.sv
module calib_engine_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              out_valid,
  input logic              drdy_n,
  input logic              in_disconnect,
  input logic [DATA_W-1:0] offset_word,
  input logic [DATA_W-1:0] gain_word,
  input logic              cal_accept,
  input logic              ofs_load,
  input logic              gain_load
);

  a_r12_no_output_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !out_valid);

  a_r13_accept_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_accept |=> busy);

  a_r13_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cal_accept);

  a_r4_offset_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_word) |-> $past(ofs_load));

  a_r5_gain_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_word) |-> $past(gain_load));

  a_r7_disconnect_inside_cal: assert property (@(posedge clk) disable iff (!rst_n)
    in_disconnect |-> busy);

  a_r9_not_ready_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> drdy_n);

  a_r9_ready_at_completion: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !drdy_n);

endmodule

bind calib_engine calib_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .out_valid    (out_valid),
  .drdy_n       (drdy_n),
  .in_disconnect(in_disconnect),
  .offset_word  (offset_word),
  .gain_word    (gain_word),
  .cal_accept   (cal_accept),
  .ofs_load     (ofs_load),
  .gain_load    (gain_load)
);

// File: tb/test_calib_engine.sv
module test_calib_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start = 1'b0;
  logic [2:0]  cal_op = 3'd0;
  logic        raw_valid = 1'b0;
  logic [23:0] raw_data = '0;
  logic        out_valid;
  logic [23:0] out_data;
  logic        drdy_n, busy, in_disconnect, odac_disable;
  logic [23:0] offset_word, gain_word;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int  m_phase = 0;   // 0 idle, 1 ofs settle, 2 ofs measure, 3 gain settle, 4 gain measure
  bit  m_both  = 0;
  bit  m_self  = 0;
  bit  m_skip  = 0;
  bit  m_drdy  = 1;
  int  m_off   = 0;
  longint m_gain = 64'h400000;

  localparam int GAP = 70;

  always #5 clk = ~clk;

  calib_engine i_calib_engine (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cal_op(cal_op),
    .raw_valid(raw_valid), .raw_data(raw_data), .out_valid(out_valid),
    .out_data(out_data), .drdy_n(drdy_n), .busy(busy),
    .in_disconnect(in_disconnect), .odac_disable(odac_disable),
    .offset_word(offset_word), .gain_word(gain_word)
  );

  function automatic int sx(input logic [23:0] v);
    return int'($signed(v));
  endfunction

  function automatic longint ref_gain(input int fs, input int off);
    longint d, q;
    d = longint'(fs) - longint'(off);
    if (d <= 0) return 64'hFFFFFF;
    q = (longint'(24'h7FFFFF) * 4194304) / d;
    return (q > 64'hFFFFFF) ? 64'hFFFFFF : q;
  endfunction

  function automatic int ref_out(input int raw, input int off, input longint g);
    longint p, s;
    p = (longint'(raw) - longint'(off)) * g;
    s = p >>> 22;
    if (s > 8388607)  s = 8388607;
    if (s < -8388608) s = -8388608;
    return int'(s);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " busy"}, busy, (m_phase != 0));
    chk({req, " odac_disable (R8)"}, odac_disable, (m_phase != 0));
    chk({req, " in_disconnect (R7)"}, in_disconnect, (m_phase != 0) && m_self);
    chk({req, " drdy_n (R9)"}, drdy_n, m_drdy);
    chk({req, " offset_word (R4)"}, offset_word, longint'(m_off) & 64'hFFFFFF);
    chk({req, " gain_word (R5)"}, gain_word, m_gain);
  endtask

  task automatic start_cal(input logic [2:0] op);
    @(negedge clk);
    cal_start = 1'b1;
    cal_op    = op;
    @(negedge clk);
    cal_start = 1'b0;
    if (m_phase == 0 && op <= 3'd4) begin
      m_both  = (op == 3'd0);
      m_self  = (op <= 3'd2);
      m_phase = (op == 3'd0 || op == 3'd1 || op == 3'd3) ? 1 : 3;
      m_drdy  = 1;
    end
    check_state("R2/R13 request");
  endtask

  task automatic send_sample(input int v);
    bit exp_v;
    int exp_d;
    exp_v = 0;
    exp_d = 0;
    @(negedge clk);
    raw_valid = 1'b1;
    raw_data  = v[23:0];
    // model reacts to the sample
    case (m_phase)
      0: begin
        if (m_skip) m_skip = 0;
        else begin
          exp_v  = 1;
          exp_d  = ref_out(v, m_off, m_gain);
          m_drdy = 0;
        end
      end
      1: m_phase = 2;
      2: begin
        m_off = v;
        if (m_both) m_phase = 3;
        else begin m_phase = 0; m_skip = 1; m_drdy = 0; end
      end
      3: m_phase = 4;
      default: begin
        m_gain  = ref_gain(v, m_off);
        m_phase = 0; m_skip = 1; m_drdy = 0;
      end
    endcase
    @(negedge clk);
    raw_valid = 1'b0;
    chk("R10/R11/R12 out_valid", out_valid, exp_v);
    if (exp_v) chk("R11 out_data", out_data, longint'(exp_d) & 64'hFFFFFF);
    for (int i = 0; i < GAP; i++) begin
      @(negedge clk);
      if (out_valid) begin
        fails++;
        $display("FAIL R12: got out_valid 1 expected 0 between samples");
      end
    end
    check_state("R3/R6 after sample");
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 offset", offset_word, 0);
    chk("R1 gain", gain_word, 24'h400000);
    chk("R1 busy", busy, 0);
    chk("R1 drdy_n", drdy_n, 1);
    chk("R1 in_disconnect", in_disconnect, 0);
    chk("R1 odac_disable", odac_disable, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 pass-through with unity gain
    send_sample(24'h100000);
    send_sample(-1234567);
    send_sample(24'h7FFFFF);

    // R2 illegal code ignored
    start_cal(3'd6);
    send_sample(4096);

    // R3/R4 system offset, R13 collision check happens later
    start_cal(3'd3);
    send_sample(999);
    send_sample(24'h001000);
    send_sample(5000);        // R10 dropped
    send_sample(5000);        // R11 published with offset removed

    // R5 system gain with a request in the middle (R13)
    start_cal(3'd4);
    send_sample(24'h300000);
    start_cal(3'd1);
    send_sample(24'h401000);
    send_sample(24'h200000);  // R10 dropped
    send_sample(24'h7FF000);  // R11 saturate high
    send_sample(-8388000);    // R11 saturate low
    send_sample(24'h101000);

    // R6/R7 combined self calibration with negative offset
    start_cal(3'd0);
    send_sample(77);
    send_sample(-256);
    send_sample(24'h123456);
    send_sample(24'h200000);
    send_sample(0);           // R10 dropped
    send_sample(24'h180000);
    send_sample(-3000000);

    // R5 nonpositive divisor in self gain
    start_cal(3'd2);
    send_sample(0);
    send_sample(-1000);
    send_sample(1);
    send_sample(-200);

    // R7 self offset only
    start_cal(3'd1);
    send_sample(10);
    send_sample(24'h000200);
    send_sample(10);
    send_sample(24'h000300);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule